// File: doc/BRIEF.md
# Odd-Even Transposition Register Sorter

This block sorts a batch of unsigned values held in a bank of registers. Values enter one per clock through a serial shift path while the block waits in state IDLE. A start pulse moves it to state SORT. In SORT, every clock applies one compare-and-exchange phase over adjacent register pairs, and all pairs of that phase work in parallel. Phases that pair even-indexed slots with their upper neighbours alternate with phases that pair odd-indexed slots with theirs. After as many phases as there are items, the bank is in ascending order.

The block then enters state UNLOAD and shifts the result out one value per clock, smallest first. Because of this, no wide read multiplexer is needed. Slots that were never loaded hold zero and are sorted as zero.

The state machine has three states, IDLE, SORT and UNLOAD, and three transitions:
- IDLE to SORT, taken when start is high.
- SORT to UNLOAD, taken at the clock edge that completes the last phase.
- UNLOAD to IDLE, taken at the edge that follows the last output value.

Top module: `trans_sorter`

## Requirements
- R1: In IDLE, each cycle with in_valid high shifts in_data into the top slot, and every slot moves down by one. After N_ITEMS loads, the first value loaded sits in slot 0. A valid value on the same cycle as start is still accepted.
- R2: start in IDLE begins sorting at the next clock. SORT lasts exactly N_ITEMS cycles, and out_valid stays low during all of them.
- R3: The unloaded sequence is in ascending order and is a permutation of the bank contents at start. Equal values are never exchanged.
- R4: done is high for exactly one cycle, the first cycle after the final phase. That is the first UNLOAD cycle.
- R5: out_valid is high for exactly N_ITEMS consecutive cycles. out_data carries slot 0 first, then each following slot in turn.
- R6: in_valid and start have no effect while the block is in SORT.
- R7: in_valid and start have no effect while the block is in UNLOAD. After unloading, every slot of the bank holds zero.
- R8: After reset, out_valid and done are low, out_data is zero, and every slot holds zero.
- R9: A partial load of k < N_ITEMS values sorts as if the other N_ITEMS-k slots held zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load strobe for in_data (honoured only in IDLE) |
| in_data | input | DATA_W | Unsigned value to load |
| start | input | 1 | Begins a sort (honoured only in IDLE) |
| done | output | 1 | One-cycle pulse on the first output cycle |
| out_valid | output | 1 | High while sorted values are being shifted out |
| out_data | output | DATA_W | Current output value (slot 0 of the bank) |

## Verification
A wrong phase parity or a missing compare unit leaves some pair out of order. This shows up as a descent in out_data within the same unload. A phase count that is off by one moves the done pulse and the whole out_valid window by a cycle, which is seen on the first cycle after SORT. An input that leaks through during SORT or UNLOAD corrupts either the current output stream or the zero-filled bank. The corruption appears in the values of the next unload.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SORT   = 2'd1,
        ST_UNLOAD = 2'd2
    } sort_state_t;
endpackage

// File: rtl/sorter_cas.sv
// Compare-and-exchange unit: keeps order when a <= b (stable for equals).
module sorter_cas #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi
);
    logic swap;
    assign swap = (a > b);
    assign lo   = swap ? b : a;
    assign hi   = swap ? a : b;
endmodule

// File: rtl/sorter_bank.sv
// Register bank with a serial shift path and a parallel transposition network.
module sorter_bank #(
    parameter int N_ITEMS = 48,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] shift_in,
    input  logic              phase_en,
    input  logic              phase_odd,
    output logic [DATA_W-1:0] head
);
    localparam int N_PAIRS = N_ITEMS - 1;

    logic [DATA_W-1:0] slot   [N_ITEMS];
    logic [DATA_W-1:0] nxt    [N_ITEMS];
    logic [DATA_W-1:0] lo_v   [N_PAIRS];
    logic [DATA_W-1:0] hi_v   [N_PAIRS];
    logic [N_PAIRS-1:0] pair_on;

    for (genvar j = 0; j < N_PAIRS; j++) begin : g_pair
        localparam bit ODD_J = ((j % 2) == 1);
        sorter_cas #(.DATA_W(DATA_W)) u_cas (
            .a  (slot[j]),
            .b  (slot[j+1]),
            .lo (lo_v[j]),
            .hi (hi_v[j])
        );
        assign pair_on[j] = phase_en && (phase_odd == ODD_J);
    end

    for (genvar i = 0; i < N_ITEMS; i++) begin : g_next
        if (i == 0) begin : g_first
            assign nxt[i] = pair_on[0] ? lo_v[0] : slot[0];
        end else if (i == N_ITEMS - 1) begin : g_last
            assign nxt[i] = pair_on[i-1] ? hi_v[i-1] : slot[i];
        end else begin : g_mid
            assign nxt[i] = pair_on[i]   ? lo_v[i]   :
                            pair_on[i-1] ? hi_v[i-1] : slot[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_ITEMS; k++) slot[k] <= '0;
        end else if (shift_en) begin
            for (int k = 0; k < N_ITEMS - 1; k++) slot[k] <= slot[k+1];
            slot[N_ITEMS-1] <= shift_in;
        end else begin
            for (int k = 0; k < N_ITEMS; k++) slot[k] <= nxt[k];
        end
    end

    assign head = slot[0];
endmodule

// File: rtl/sorter_ctrl.sv
// Sequencer: IDLE (load) -> SORT (N_ITEMS phases) -> UNLOAD (N_ITEMS outputs).
module sorter_ctrl
    import sorter_pkg::*;
#(
    parameter int N_ITEMS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              start,
    output sort_state_t       state,
    output logic [$clog2(N_ITEMS)-1:0] cnt,
    output logic              shift_en,
    output logic              zero_fill,
    output logic              phase_en,
    output logic              phase_odd,
    output logic              done,
    output logic              out_valid
);
    localparam int CW = $clog2(N_ITEMS);
    localparam logic [CW-1:0] LAST = CW'(N_ITEMS - 1);

    sort_state_t nxt_state;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:   if (start)       nxt_state = ST_SORT;
            ST_SORT:   if (cnt == LAST) nxt_state = ST_UNLOAD;
            ST_UNLOAD: if (cnt == LAST) nxt_state = ST_IDLE;
            default:                    nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            if (nxt_state != state)   cnt <= '0;
            else if (state != ST_IDLE) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        shift_en  = 1'b0;
        zero_fill = 1'b0;
        phase_en  = 1'b0;
        phase_odd = cnt[0];
        done      = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE:   shift_en = in_valid;
            ST_SORT:   phase_en = 1'b1;
            ST_UNLOAD: begin
                shift_en  = 1'b1;
                zero_fill = 1'b1;
                out_valid = 1'b1;
                done      = (cnt == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trans_sorter.sv
module trans_sorter
    import sorter_pkg::*;
#(
    parameter int N_ITEMS = 48,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              start,
    output logic              done,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW = $clog2(N_ITEMS);

    sort_state_t       st;
    logic [CW-1:0]     cnt;
    logic              shift_en, zero_fill, phase_en, phase_odd;
    logic [DATA_W-1:0] shift_in;

    sorter_ctrl #(.N_ITEMS(N_ITEMS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .start     (start),
        .state     (st),
        .cnt       (cnt),
        .shift_en  (shift_en),
        .zero_fill (zero_fill),
        .phase_en  (phase_en),
        .phase_odd (phase_odd),
        .done      (done),
        .out_valid (out_valid)
    );

    assign shift_in = zero_fill ? '0 : in_data;

    sorter_bank #(.N_ITEMS(N_ITEMS), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .shift_in  (shift_in),
        .phase_en  (phase_en),
        .phase_odd (phase_odd),
        .head      (out_data)
    );
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker
    import sorter_pkg::*;
#(
    parameter int N_ITEMS = 48,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input sort_state_t       state,
    input logic [$clog2(N_ITEMS)-1:0] cnt,
    input logic              done,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int CW = $clog2(N_ITEMS);
    localparam logic [CW-1:0] LAST = CW'(N_ITEMS - 1);

    p_sort_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SORT && cnt == LAST) |=> (state == ST_UNLOAD && out_valid));

    p_sort_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SORT) |-> !out_valid);

    p_sort_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SORT && cnt != LAST) |=> (state == ST_SORT && cnt == $past(cnt) + 1'b1));

    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |-> (out_data >= $past(out_data)));

    p_done_after_sort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_SORT && out_valid));

    p_valid_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |-> $past(out_valid));

    p_unload_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNLOAD && cnt == LAST) |=> (state == ST_IDLE && !out_valid));
endmodule

bind trans_sorter sorter_checker #(.N_ITEMS(N_ITEMS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st),
    .cnt       (cnt),
    .done      (done),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_trans_sorter.sv
module tb_trans_sorter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 48;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         start = 1'b0;
    logic         done, out_valid;
    logic [W-1:0] out_data;

    trans_sorter #(.N_ITEMS(N), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .start(start), .done(done), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    mb [N];
    int    mstate = 0;   // 0 idle, 1 sort, 2 unload
    int    mcnt = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    seed = 17;
    string cur_req = "R8";

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_sort();
        for (int i = 1; i < N; i++) begin
            int key = mb[i];
            int j = i - 1;
            while (j >= 0 && mb[j] > key) begin
                mb[j+1] = mb[j];
                j--;
            end
            mb[j+1] = key;
        end
    endtask

    task automatic model_edge(input bit v, input int d, input bit st);
        case (mstate)
            0: begin
                if (v) begin
                    for (int i = 0; i < N-1; i++) mb[i] = mb[i+1];
                    mb[N-1] = d;
                end
                if (st) begin mstate = 1; mcnt = 0; end
            end
            1: begin
                if (mcnt == N-1) begin model_sort(); mstate = 2; mcnt = 0; end
                else mcnt++;
            end
            default: begin
                for (int i = 0; i < N-1; i++) mb[i] = mb[i+1];
                mb[N-1] = 0;
                if (mcnt == N-1) begin mstate = 0; mcnt = 0; end
                else mcnt++;
            end
        endcase
    endtask

    task automatic compare_all();
        chk("R5 out_valid", int'(out_valid), (mstate == 2) ? 1 : 0);
        chk("R4 done", int'(done), (mstate == 2 && mcnt == 0) ? 1 : 0);
        if (mstate == 2) chk({cur_req, " out_data"}, int'(out_data), mb[0]);
    endtask

    task automatic cyc(input bit v, input int d, input bit st);
        in_valid = v;
        in_data  = W'(d);
        start    = st;
        @(posedge clk);
        model_edge(v, d, st);
        @(negedge clk);
        compare_all();
    endtask

    // Run from the start pulse until back in IDLE; optional noise on inputs.
    task automatic run_job(input bit noise_sort, input bit noise_unload);
        cyc(1'b0, 0, 1'b1);
        do begin
            bit nz = (mstate == 1 && noise_sort) || (mstate == 2 && noise_unload);
            cyc(nz, nz ? ((mstate == 1) ? 255 : 170) : 0, nz);
        end while (mstate != 0);
    endtask

    function automatic int next_rand();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >>> 8) & 255;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mb[i] = 0;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 out_valid", int'(out_valid), 0);
        chk("R8 done", int'(done), 0);
        chk("R8 out_data", int'(out_data), 0);
        rst_n = 1'b1;
        cyc(1'b0, 0, 1'b0);
        cyc(1'b0, 0, 1'b0);

        // R1 R2 R3: full random load with duplicates
        cur_req = "R1 R2 R3";
        for (int i = 0; i < N; i++) cyc(1'b1, (i % 3 == 0) ? 42 : next_rand(), 1'b0);
        run_job(1'b0, 1'b0);

        // R6: reverse order, noise on in_valid/start during SORT
        cur_req = "R6 R3";
        for (int i = 0; i < N; i++) cyc(1'b1, 250 - i*5, 1'b0);
        run_job(1'b1, 1'b0);

        // R3: all equal values
        cur_req = "R3 equal";
        for (int i = 0; i < N; i++) cyc(1'b1, 128, 1'b0);
        run_job(1'b0, 1'b0);

        // R7 R9: partial load, noise during UNLOAD
        cur_req = "R7 R9";
        for (int i = 0; i < 5; i++) cyc(1'b1, 200 - i*37, 1'b0);
        run_job(1'b0, 1'b1);

        // R7 R9: bank must be zero after unload; short load, extremes
        cur_req = "R7 R9 zeroed";
        cyc(1'b1, 255, 1'b0);
        cyc(1'b1, 0, 1'b0);
        cyc(1'b1, 1, 1'b0);
        run_job(1'b0, 1'b0);

        // R1: value presented together with start is accepted
        cur_req = "R1 R3 start-cycle load";
        for (int i = 0; i < N-1; i++) cyc(1'b1, next_rand(), 1'b0);
        cyc(1'b1, 7, 1'b1);
        do cyc(1'b0, 0, 1'b0); while (mstate != 0);

        cyc(1'b0, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule